// File: doc/BRIEF.md
# Branch History Table Predictor

This block gives the fetch stage a direction guess and a target for the instruction at the current fetch PC. It holds a direct-mapped table. Each entry carries a valid flag, an address tag, a cached target address and a small amount of history. When the lookup hits, fetch can redirect straight to the stored target without recomputing it. When the lookup misses, a fixed rule based on the branch displacement sign gives the direction. A displacement that points backward is guessed taken, and one that points forward is guessed not taken.

Once a branch resolves, the update port reports its PC, its actual direction and its actual target. On a hit, this moves the entry's history and can refresh its target. On a miss, an entry is claimed only when the branch was taken.

A parameter chooses how much history each entry keeps. With one bit, the entry remembers only the last outcome. With two bits, it holds a saturating counter, so a single surprise outcome does not reverse a firmly held guess.

Lookup is purely combinational within the fetch cycle. Table writes happen on the rising clock edge.

Top module: `bht_predictor`

## Requirements
- R1: The table index is PC bits [OFF_W+IDX_W-1:OFF_W] and the tag is the remaining upper bits. A lookup hits only if the indexed entry is valid and its tag equals the PC tag. A PC that shares the index but has a different tag is a miss.
- R2: On a miss, `pr_hit` is 0, `pr_target` is all zeros and `pr_taken` equals `lk_back` (1 = backward displacement, predicted taken).
- R3: On a hit, `pr_target` is the target stored in the entry, and `pr_hit` is 1.
- R4: With TWO_BIT=1, each entry holds a counter. Codes 00 and 01 predict not taken, and 10 and 11 predict taken. A resolved taken outcome on a hit increments the counter, saturating at 11. A resolved not-taken outcome decrements it, saturating at 00.
- R5: With TWO_BIT=0, a hit predicts the direction the branch took on its last resolved execution.
- R6: A resolved taken branch that misses claims its entry: valid is set, and the tag and target are written. The counter starts at 10 in two-bit mode, and the bit starts at taken in one-bit mode. A resolved not-taken branch that misses changes nothing.
- R7: A resolved taken branch that hits overwrites the stored target with the resolved target. A resolved not-taken branch that hits keeps the stored target.
- R8: An update is visible to lookups from the cycle after its clock edge. A lookup in the same cycle as an update to the same entry sees the old contents.
- R9: A synchronous active-high reset invalidates every entry, so every lookup after reset misses until a new entry is claimed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W | Fetch PC being looked up |
| lk_back | input | 1 | Displacement sign from decode, 1 = backward |
| pr_hit | output | 1 | Lookup found a matching valid entry |
| pr_taken | output | 1 | Predicted direction, 1 = taken |
| pr_target | output | PC_W | Cached target on a hit, zero on a miss |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Resolved direction, 1 = taken |
| up_target | input | PC_W | Resolved target address |

## Verification
The assertions assume the update PC is stable and defined whenever `up_valid` is high. They also assume that a check starting from an update is only evaluated when no reset arrives in the following cycle. The stimulus drives only word-aligned PCs and keeps every input defined from the first edge. It changes inputs only on the falling edge.

The stimulus draws PCs from a small set of tags and indices so that aliasing, entry replacement and same-cycle lookup-versus-update collisions occur often. It applies reset only with `up_valid` low.

// File: rtl/bht_pkg.sv
package bht_pkg;
  // two-bit counter codes; the upper bit is the predicted direction
  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr2_e;

  function automatic logic [1:0] ctr2_step(input logic [1:0] cur, input logic taken);
    logic [1:0] r;
    if (taken) r = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
    else       r = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return r;
  endfunction
endpackage

// File: rtl/bht_ctr_next.sv
module bht_ctr_next #(
  parameter int TWO_BIT = 1,
  localparam int SW = (TWO_BIT != 0) ? 2 : 1
) (
  input  logic [SW-1:0] cur,
  input  logic          taken,
  output logic [SW-1:0] nxt
);
  import bht_pkg::*;

  generate
    if (TWO_BIT != 0) begin : g_two
      always_comb nxt = ctr2_step(cur, taken);

      always_comb begin
        if (cur == CTR_STRONG_T && taken)
          a_r4_sat_top: assert (nxt == CTR_STRONG_T);
        if (cur == CTR_STRONG_NT && !taken)
          a_r4_sat_bot: assert (nxt == CTR_STRONG_NT);
        if (taken && cur != CTR_STRONG_T)
          a_r4_step_up: assert (nxt[SW-1] || cur == CTR_STRONG_NT);
      end
    end else begin : g_one
      always_comb nxt = taken;
    end
  endgenerate
endmodule

// File: rtl/bht_store.sv
module bht_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26,
  parameter int PC_W  = 32,
  parameter int SW    = 2,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] a_idx,
  output logic             a_valid,
  output logic [TAG_W-1:0] a_tag,
  output logic [PC_W-1:0]  a_tgt,
  output logic [SW-1:0]    a_st,
  input  logic [IDX_W-1:0] b_idx,
  output logic             b_valid,
  output logic [TAG_W-1:0] b_tag,
  output logic [SW-1:0]    b_st,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [SW-1:0]    wr_st,
  input  logic             wr_tgt_en,
  input  logic [PC_W-1:0]  wr_tgt
);
  logic [DEPTH-1:0] valid_q;
  logic [TAG_W-1:0] tag_m [DEPTH];
  logic [PC_W-1:0]  tgt_m [DEPTH];
  logic [SW-1:0]    st_m  [DEPTH];

  // valid flags need reset, so they sit in flops
  always_ff @(posedge clk) begin
    if (rst)        valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  // payload arrays carry no reset so they can map onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_m[wr_idx] <= wr_tag;
      st_m[wr_idx]  <= wr_st;
      if (wr_tgt_en) tgt_m[wr_idx] <= wr_tgt;
    end
  end

  assign a_valid = valid_q[a_idx];
  assign a_tag   = tag_m[a_idx];
  assign a_tgt   = tgt_m[a_idx];
  assign a_st    = st_m[a_idx];
  assign b_valid = valid_q[b_idx];
  assign b_tag   = tag_m[b_idx];
  assign b_st    = st_m[b_idx];
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 4,
  parameter int OFF_W   = 2,
  parameter int TWO_BIT = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            lk_back,
  output logic            pr_hit,
  output logic            pr_taken,
  output logic [PC_W-1:0] pr_target,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target
);
  localparam int TAG_W = PC_W - IDX_W - OFF_W;
  localparam int SW    = (TWO_BIT != 0) ? 2 : 1;
  localparam logic [SW-1:0] INIT_ST = SW'(1) << (SW - 1);

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             unused_offset;

  assign lk_idx = lk_pc[OFF_W +: IDX_W];
  assign up_idx = up_pc[OFF_W +: IDX_W];
  assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
  assign up_tag = up_pc[PC_W-1 -: TAG_W];
  assign unused_offset = ^{lk_pc[OFF_W-1:0], up_pc[OFF_W-1:0]};

  logic             a_valid, b_valid;
  logic [TAG_W-1:0] a_tag, b_tag;
  logic [PC_W-1:0]  a_tgt;
  logic [SW-1:0]    a_st, b_st, ctr_nxt, wr_st;
  logic             lk_hit, up_hit, wr_en;

  bht_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W), .SW(SW)) store_i (
    .clk(clk), .rst(rst),
    .a_idx(lk_idx), .a_valid(a_valid), .a_tag(a_tag), .a_tgt(a_tgt), .a_st(a_st),
    .b_idx(up_idx), .b_valid(b_valid), .b_tag(b_tag), .b_st(b_st),
    .wr_en(wr_en), .wr_idx(up_idx), .wr_tag(up_tag), .wr_st(wr_st),
    .wr_tgt_en(up_taken), .wr_tgt(up_target)
  );

  bht_ctr_next #(.TWO_BIT(TWO_BIT)) ctr_i (
    .cur(b_st), .taken(up_taken), .nxt(ctr_nxt)
  );

  // lookup side
  assign lk_hit    = a_valid && (a_tag == lk_tag);
  assign pr_hit    = lk_hit;
  assign pr_taken  = lk_hit ? a_st[SW-1] : lk_back;
  assign pr_target = lk_hit ? a_tgt : '0;

  // update side: train on hit, claim only on a taken miss
  assign up_hit = b_valid && (b_tag == up_tag);
  assign wr_en  = up_valid && (up_hit || up_taken);
  assign wr_st  = up_hit ? ctr_nxt : INIT_ST;

  // R3 / R7 / R8: a taken update is visible with its target one cycle later
  a_r7_fresh_target: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_taken) ##1 (lk_pc == $past(up_pc))
      |-> (pr_hit && pr_target == $past(up_target)));

  // R9: after a reset edge nothing hits
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> !pr_hit);

  generate
    if (TWO_BIT == 0) begin : g_one_chk
      // R5: last outcome taken means predicted taken
      a_r5_last_taken: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_taken) ##1 (lk_pc == $past(up_pc)) |-> pr_taken);
    end
  endgenerate
endmodule

// File: tb/bht_predictor_tb_top.sv
`timescale 1ns/1ps
module bht_predictor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_pc = '0;
  logic        lk_back = 1'b0;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;
  logic [31:0] up_target = '0;

  logic        h2, t2, h1, t1;
  logic [31:0] g2, g1;

  always #2 clk = ~clk;

  bht_predictor #(.TWO_BIT(1)) dut_i (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_back(lk_back),
    .pr_hit(h2), .pr_taken(t2), .pr_target(g2),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target));

  bht_predictor #(.TWO_BIT(0)) dut1_i (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_back(lk_back),
    .pr_hit(h1), .pr_taken(t1), .pr_target(g1),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target));

  // behavioural model of the table
  bit          mv [16];
  int          mtag [16];
  logic [31:0] mtgt [16];
  int          m2 [16];
  bit          m1 [16];

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  function automatic logic [31:0] mkpc(int tag, int idx);
    return (32'(tag) << 6) | (32'(idx) << 2);
  endfunction

  task automatic cmp(string req, int mode, logic h, logic t, logic [31:0] g,
                     logic eh, logic et, logic [31:0] eg);
    n_checks++;
    if (h !== eh || t !== et || g !== eg) begin
      n_fail++;
      $display("FAIL %s mode=%0d got hit=%b taken=%b tgt=%h exp hit=%b taken=%b tgt=%h",
               req, mode, h, t, g, eh, et, eg);
    end
  endtask

  task automatic step(string req, logic [31:0] pc, logic back,
                      logic uv, logic [31:0] upc, logic ut, logic [31:0] utg);
    int i, tg, ui, utag;
    bit hit, uh;
    @(negedge clk);
    lk_pc = pc; lk_back = back;
    up_valid = uv; up_pc = upc; up_taken = ut; up_target = utg;
    #1;
    i  = int'(pc[5:2]);
    tg = int'(pc[31:6]);
    hit = mv[i] && mtag[i] == tg;
    cmp(req, 2, h2, t2, g2, hit, hit ? (m2[i] >= 2) : back, hit ? mtgt[i] : 32'h0);
    cmp(req, 1, h1, t1, g1, hit, hit ? m1[i] : back, hit ? mtgt[i] : 32'h0);
    @(posedge clk);
    if (uv) begin
      ui = int'(upc[5:2]);
      utag = int'(upc[31:6]);
      uh = mv[ui] && mtag[ui] == utag;
      if (uh) begin
        m2[ui] = ut ? ((m2[ui] < 3) ? m2[ui] + 1 : 3) : ((m2[ui] > 0) ? m2[ui] - 1 : 0);
        m1[ui] = ut;
        if (ut) mtgt[ui] = utg;
      end else if (ut) begin
        mv[ui] = 1; mtag[ui] = utag; mtgt[ui] = utg; m2[ui] = 2; m1[ui] = 1;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; up_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 16; k++) mv[k] = 0;
  endtask

  task automatic look(string req, logic [31:0] pc, logic back);
    step(req, pc, back, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic upd(string req, logic [31:0] pc, logic ut, logic [31:0] tg);
    step(req, pc, 1'b0, 1'b1, pc, ut, tg);
  endtask

  initial begin
    logic [31:0] pa, pb;
    pa = mkpc(5, 3);
    pb = mkpc(9, 3);
    do_reset();
    // R9: empty after reset
    look("R9", pa, 1'b0);
    // R2: static rule on miss
    look("R2", pa, 1'b1);
    look("R2", mkpc(2, 7), 1'b0);
    // R6: not-taken miss claims nothing
    upd("R6", pa, 1'b0, 32'h1000);
    look("R6", pa, 1'b0);
    // R6 / R8: taken miss claims; same-cycle lookup sees old
    step("R8", pa, 1'b0, 1'b1, pa, 1'b1, 32'h1000);
    look("R6", pa, 1'b0);
    look("R3", pa, 1'b1);
    // R4 / R5: history walks; R7 target kept on not taken
    upd("R4", pa, 1'b0, 32'hdead0000); look("R7", pa, 1'b0);
    upd("R4", pa, 1'b0, 32'h0);        look("R4", pa, 1'b1);
    upd("R4", pa, 1'b0, 32'h0);        look("R4", pa, 1'b1);
    upd("R5", pa, 1'b1, 32'h1000);     look("R5", pa, 1'b0);
    upd("R4", pa, 1'b1, 32'h1000);     look("R4", pa, 1'b0);
    upd("R4", pa, 1'b1, 32'h1000);
    upd("R4", pa, 1'b1, 32'h1000);     look("R4", pa, 1'b0);
    upd("R5", pa, 1'b0, 32'h0);        look("R5", pa, 1'b0);
    // R7: taken hit refreshes target
    upd("R7", pa, 1'b1, 32'h2000);     look("R7", pa, 1'b0);
    // R1: alias with other tag misses, then replaces the entry
    look("R1", pb, 1'b1);
    upd("R1", pb, 1'b1, 32'h3000);
    look("R1", pb, 1'b0);
    look("R1", pa, 1'b0);
    // R9: reset in mid run
    do_reset();
    look("R9", pb, 1'b0);
    // mixed traffic over a few tags and indices
    for (int n = 0; n < 600; n++) begin
      logic [31:0] lp, upp;
      lp  = mkpc(int'($urandom_range(0, 2)), int'($urandom_range(0, 3)));
      upp = ($urandom_range(0, 3) == 0) ? lp
            : mkpc(int'($urandom_range(0, 2)), int'($urandom_range(0, 3)));
      step("R1", lp, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), upp,
           1'($urandom_range(0, 1)), {$urandom_range(0, 65535), 16'h0});
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog R9 run did not finish got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule